// File: doc/BRIEF.md
# Wake-Domain Interrupt Aggregator

This block sits in the always-on domain. It takes 64 interrupt levels from the application domain and folds them into two request lines for a small 8-bit wake-up controller. Each line has its own 64-bit enable mask. A line is raised when any source enabled in its mask is active. The incoming levels are first brought into the local clock through a two-flop synchronizer.

A global bridge bit gates every application-domain request. Each line also has its own unmask bit. After both gates, each line is ORed with a group of local always-on interrupt levels. The result drives one registered, active-low external interrupt pin: line 0 drives pin 0 and line 1 drives pin 1. Software reaches the block through a plain word-wide register port. Writes take effect on the clock edge. Reads are combinational from the address. For each line, a live status view shows which enabled sources are active.

Register map (word address): 0 control (bit 0 bridge enable, bit 1 unmask line 0, bit 2 unmask line 1), 1 and 2 line-0 enables (sources 31:0, then 63:32), 3 and 4 line-1 enables (same split), 5 and 6 line-0 status, 7 and 8 line-1 status.

Top module: `wake_irq_fold`

## Requirements
- R1: After reset both interrupt pins are high and the control and enable registers read 0.
- R2: A write to address 1, 2, 3 or 4 stores the full data word in that enable register, and the same address reads it back.
- R3: Line k asserts when any synchronized source whose bit is set in line k's 64-bit mask is high. Pin k (active low) then goes low on the third clock edge after the source changes, provided that bridge and unmask k are set.
- R4: Status addresses 5 to 8 read the live synchronized sources ANDed with the matching mask half, with no latching. Writes to these addresses have no effect.
- R5: With control bit 0 (bridge) clear, no application source can pull either pin low. Status still reports enabled active sources.
- R6: With control bit 1+k clear, line k cannot pull pin k low. The other line is unaffected.
- R7: Any local source of group k pulls pin k low one clock edge later, whatever the bridge, unmask and mask settings are.
- R8: A source enabled only in line 1's mask affects only pin 1, and the converse holds for line 0.
- R9: Addresses 9 to 15 read 0, and writes to them change no register.
- R10: A source change is not visible on a pin after only two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| app_irq_i | input | 64 | Application-domain interrupt levels (asynchronous) |
| local_irq0_i | input | 4 | Local interrupt levels shared onto pin 0 |
| local_irq1_i | input | 4 | Local interrupt levels shared onto pin 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| ext_int0_n_o | output | 1 | Active-low interrupt pin 0 |
| ext_int1_n_o | output | 1 | Active-low interrupt pin 1 |

## Verification
The bench tries five kinds of source pattern:
- A source enabled in only one line's mask, in the low word. This separates the two OR trees.
- A source in the high word. This shows that the upper mask half is wired to the upper sources.
- A source that no mask enables. This proves that unmasked levels are dropped.
- A mix of sources under each gate setting. This separates the bridge bit from the per-line unmask bits.
- Local sources with every gate closed. These show that the shared pin path bypasses the gates.

Pins are sampled after two edges and again after three. This tells a correct two-flop synchronizer apart from one that is too short.

// File: rtl/wif_pkg.sv
package wif_pkg;
  localparam int DW   = 32;
  localparam int NSRC = 2 * DW;
  localparam int AW   = 4;
  localparam int NLINE = 2;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 4'd0,
    A_EN0_LO = 4'd1,
    A_EN0_HI = 4'd2,
    A_EN1_LO = 4'd3,
    A_EN1_HI = 4'd4,
    A_ST0_LO = 4'd5,
    A_ST0_HI = 4'd6,
    A_ST1_LO = 4'd7,
    A_ST1_HI = 4'd8
  } wif_addr_e;
endpackage

// File: rtl/wif_sync.sv
module wif_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/wif_regs.sv
module wif_regs
  import wif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] st0_i,
  input  logic [NSRC-1:0] st1_i,
  output logic            bridge_o,
  output logic [1:0]      unmask_o,
  output logic [NSRC-1:0] en0_o,
  output logic [NSRC-1:0] en1_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bridge_o <= 1'b0;
      unmask_o <= '0;
      en0_o    <= '0;
      en1_o    <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          bridge_o <= wdata_i[0];
          unmask_o <= wdata_i[2:1];
        end
        A_EN0_LO: en0_o[DW-1:0]    <= wdata_i;
        A_EN0_HI: en0_o[NSRC-1:DW] <= wdata_i;
        A_EN1_LO: en1_o[DW-1:0]    <= wdata_i;
        A_EN1_HI: en1_o[NSRC-1:DW] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o = {{(DW-3){1'b0}}, unmask_o, bridge_o};
      A_EN0_LO: rdata_o = en0_o[DW-1:0];
      A_EN0_HI: rdata_o = en0_o[NSRC-1:DW];
      A_EN1_LO: rdata_o = en1_o[DW-1:0];
      A_EN1_HI: rdata_o = en1_o[NSRC-1:DW];
      A_ST0_LO: rdata_o = st0_i[DW-1:0];
      A_ST0_HI: rdata_o = st0_i[NSRC-1:DW];
      A_ST1_LO: rdata_o = st1_i[DW-1:0];
      A_ST1_HI: rdata_o = st1_i[NSRC-1:DW];
      default:  rdata_o = '0;
    endcase
  end

  // R2
  en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_EN1_HI) |=> (en1_o[NSRC-1:DW] == $past(wdata_i)));

  // R9
  undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i > A_ST1_HI) |=> ($stable(en0_o) && $stable(en1_o)));
endmodule

// File: rtl/wif_fold.sv
module wif_fold #(
  parameter int NSRC = 64,
  parameter int NLOC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            bridge_i,
  input  logic            unmask_i,
  input  logic [NLOC-1:0] local_i,
  output logic [NSRC-1:0] status_o,
  output logic            int_n_o
);
  logic line_req;
  logic pin_req;

  assign status_o = src_i & mask_i;
  assign line_req = bridge_i & unmask_i & (|status_o);
  assign pin_req  = line_req | (|local_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_n_o <= 1'b1;
    else        int_n_o <= ~pin_req;
  end

  // R7
  local_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|local_i) |=> !int_n_o);

  // R5
  bridge_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bridge_i && !(|local_i)) |=> int_n_o);

  // R6
  unmask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unmask_i && !(|local_i)) |=> int_n_o);

  // R3
  mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_i && unmask_i && (|(src_i & mask_i))) |=> !int_n_o);
endmodule

// File: rtl/wake_irq_fold.sv
module wake_irq_fold
  import wif_pkg::*;
#(
  parameter int NLOC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] app_irq_i,
  input  logic [NLOC-1:0] local_irq0_i,
  input  logic [NLOC-1:0] local_irq1_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            ext_int0_n_o,
  output logic            ext_int1_n_o
);
  logic [NSRC-1:0] src_s;
  logic            bridge;
  logic [1:0]      unmask;
  logic [NSRC-1:0] en [NLINE];
  logic [NSRC-1:0] st [NLINE];
  logic [NLOC-1:0] loc [NLINE];
  logic [NLINE-1:0] pin_n;

  assign loc[0] = local_irq0_i;
  assign loc[1] = local_irq1_i;

  wif_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(app_irq_i), .q_o(src_s)
  );

  wif_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .st0_i(st[0]), .st1_i(st[1]),
    .bridge_o(bridge), .unmask_o(unmask), .en0_o(en[0]), .en1_o(en[1])
  );

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    wif_fold #(.NSRC(NSRC), .NLOC(NLOC)) u_fold (
      .clk(clk), .rst_n(rst_n), .src_i(src_s), .mask_i(en[k]),
      .bridge_i(bridge), .unmask_i(unmask[k]), .local_i(loc[k]),
      .status_o(st[k]), .int_n_o(pin_n[k])
    );
  end

  assign ext_int0_n_o = pin_n[0];
  assign ext_int1_n_o = pin_n[1];
endmodule

// File: tb/wake_irq_fold_tb.sv
module wake_irq_fold_tb;
  import wif_pkg::*;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [63:0] app_irq = '0;
  logic [3:0]  loc0 = '0, loc1 = '0;
  logic        we = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        int0_n, int1_n;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_irq_fold u_dut (
    .clk(clk), .rst_n(rst_n), .app_irq_i(app_irq),
    .local_irq0_i(loc0), .local_irq1_i(loc1),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ext_int0_n_o(int0_n), .ext_int1_n_o(int1_n)
  );

  // monitor: pops expectations and compares against live outputs
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      got = (it.kind == 0) ? {31'd0, int0_n} :
            (it.kind == 1) ? {31'd0, int1_n} : rdata;
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(0);
    @(posedge clk); #1;
    we = 1; addr = a; wdata = d;
    step(1);
    we = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    push(2, exp, tag);
  endtask

  task automatic pins(bit e0, bit e1, string tag);
    push(0, {31'd0, e0}, tag);
    push(1, {31'd0, e1}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    pins(1, 1, "R1 pins after reset");
    rd(A_CTRL, 0, "R1 ctrl reset");
    rd(A_EN0_LO, 0, "R1 en0 reset");
    // R2 enable write/readback
    wr(A_EN0_LO, 32'hA5A5_5A5A);
    wr(A_EN0_HI, 32'h1234_5678);
    wr(A_EN1_LO, 32'hFFFF_0000);
    wr(A_EN1_HI, 32'h0F0F_F0F0);
    rd(A_EN0_LO, 32'hA5A5_5A5A, "R2 en0 lo");
    rd(A_EN0_HI, 32'h1234_5678, "R2 en0 hi");
    rd(A_EN1_LO, 32'hFFFF_0000, "R2 en1 lo");
    rd(A_EN1_HI, 32'h0F0F_F0F0, "R2 en1 hi");
    // R9 undefined address
    wr(4'hF, 32'hDEAD_BEEF);
    wr(4'h9, 32'hDEAD_BEEF);
    rd(4'hF, 0, "R9 undefined read");
    rd(A_EN0_LO, 32'hA5A5_5A5A, "R9 en0 untouched");
    rd(A_EN1_HI, 32'h0F0F_F0F0, "R9 en1 untouched");
    // R4 status is read-only
    wr(A_ST0_LO, 32'hFFFF_FFFF);
    rd(A_ST0_LO, 0, "R4 status write ignored");
    // set masks: line0 = src3, src40; line1 = src5
    wr(A_EN0_LO, 32'h0000_0008);
    wr(A_EN0_HI, 32'h0000_0100);
    wr(A_EN1_LO, 32'h0000_0020);
    wr(A_EN1_HI, 32'h0);
    wr(A_CTRL, 32'h7);
    step(2);
    // R3 / R10 source 3
    app_irq = 64'h8;
    step(2);
    pins(1, 1, "R10 no change after two edges");
    rd(A_ST0_LO, 32'h8, "R4 live status line0");
    rd(A_ST1_LO, 32'h0, "R8 status line1 clear");
    step(0);
    pins(0, 1, "R3/R8 src3 drives pin0 only");
    // R8 source 5 only
    app_irq = 64'h20;
    step(3);
    pins(1, 0, "R8 src5 drives pin1 only");
    rd(A_ST1_LO, 32'h20, "R4 status line1");
    rd(A_ST0_LO, 32'h0, "R4 status not latched");
    // R3 high word source 40
    app_irq = 64'h1 << 40;
    step(3);
    pins(0, 1, "R3 high word source");
    rd(A_ST0_HI, 32'h100, "R4 status high word");
    // R3 unmasked source ignored
    app_irq = 64'h1 << 10;
    step(3);
    pins(1, 1, "R3 disabled source dropped");
    rd(A_ST0_LO, 0, "R4 disabled source status");
    // R5 bridge off
    app_irq = 64'h28;
    wr(A_CTRL, 32'h6);
    step(3);
    pins(1, 1, "R5 bridge off blocks");
    rd(A_ST0_LO, 32'h8, "R5 status with bridge off");
    // R6 unmask line0 off
    wr(A_CTRL, 32'h5);
    step(2);
    pins(1, 0, "R6 line0 unmask off");
    wr(A_CTRL, 32'h3);
    step(2);
    pins(0, 1, "R6 line1 unmask off");
    // R7 local sources with everything gated
    wr(A_CTRL, 32'h0);
    app_irq = '0;
    step(3);
    loc0 = 4'b0100;
    step(1);
    pins(0, 1, "R7 local0 one edge");
    loc0 = '0; loc1 = 4'b0001;
    step(1);
    pins(1, 0, "R7 local1 one edge");
    loc1 = '0;
    step(1);
    pins(1, 1, "R7 local released");
    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule